// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software with a 7-bit down-counter that a free-running prescaler steps. Software arms the watchdog and must then refresh the counter regularly. A refresh that comes too late lets the counter fall through its timeout point. A refresh that comes too early, while the counter is still above a programmable window value, is also treated as a fault. Both cases raise a one-cycle system reset request. Just before the timeout point an early-warning flag is raised, so that software can take a last action. That flag can drive an interrupt line.

Software reaches the block through a simple strobe interface with three 32-bit words. The control word sits at byte offset 0x0, the configuration word at 0x4 and the status word at 0x8. Reads are combinational. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `wwd_top`

## Requirements
- R1: After reset, the control word at 0x0 reads 0x7F (counter 0x7F, active bit 0), the configuration word at 0x4 reads 0x7F (window 0x7F, time base 0, interrupt enable 0), the status word at 0x8 reads 0, and `rst_req` and `ewi_irq` are low.
- R2: The counter in control bits 6:0 decrements once every 2^(PRE_LOG2+TB) clock cycles, where TB is configuration bits 8:7. The first decrement lands that many cycles after the last counter write.
- R3: While the active bit (control bit 7) is set, a decrement from 0x40 to 0x3F raises `rst_req` on the same edge at which the counter becomes 0x3F.
- R4: A control write with bit 7 set makes the watchdog active. A control write with bit 7 clear leaves the active bit unchanged, and only reset clears it.
- R5: The early-warning flag (status bit 0) is set when the counter decrements to 0x40, whatever the interrupt enable is. A status write with bit 0 = 0 clears the flag. A status write with bit 0 = 1 leaves it unchanged.
- R6: The interrupt enable (configuration bit 9) is set by writing 1 and cannot be cleared by a write. `ewi_irq` is high exactly when both the flag and the enable are set.
- R7: `rst_req` is a one-cycle pulse. After it has fired once, it stays low until the block is reset, even though the counter keeps running.
- R8: A control write made while the watchdog is active and the counter is strictly greater than the window (configuration bits 6:0) raises `rst_req` in the next cycle. A control write with the counter at or below the window does not.
- R9: While the active bit is clear, the counter runs past 0x40 to 0x3F and beyond without raising `rst_req`.
- R10: A control write that sets bit 7 with counter bit 6 clear raises `rst_req` in the next cycle.
- R11: Every control write restarts the prescaler, so an earlier partial period has no effect on the next decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| ewi_irq | output | 1 | Early-warning interrupt |

## Verification
The decrement period is measured for each of the four time-base codes. The counter is sampled one cycle before and exactly at the expected step, which separates a wrong divisor from an off-by-one. The window check is swept over every counter value from 0x7F down to 0x41 against one fixed window, so the strict greater-than boundary is isolated at the window value itself. Separate sequences cover the timeout crossing with and without activation, the sticky bits under attempted clears, the flag-clear polarity, arming with bit 6 clear, and a refresh made part-way through a period. That last sequence would show a prescaler that is not restarted.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int CNT_W  = 7;
  localparam int DATA_W = 32;

  localparam int OFS_CTRL = 'h0;
  localparam int OFS_CFG  = 'h4;
  localparam int OFS_STAT = 'h8;

  localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_WARN  = 7'h40;

  typedef struct packed {
    logic             ewi_en;
    logic [1:0]       tb;
    logic [CNT_W-1:0] win;
  } cfg_t;

  function automatic logic [31:0] period_len(input int base_log2, input logic [1:0] tb);
    return 32'd1 << (base_log2 + int'(tb));
  endfunction

  function automatic logic refresh_early(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction

endpackage

// File: rtl/wwd_bus.sv
module wwd_bus
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              act,
  input  cfg_t              cfg,
  input  logic              flag,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              wr_stat,
  output logic [CNT_W-1:0]  wd_cnt,
  output logic              wd_act,
  output cfg_t              wd_cfg,
  output logic              wd_flag,
  output logic [DATA_W-1:0] rdata
);

  logic hit_ctrl, hit_cfg, hit_stat;
  logic unused_wdata;

  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_cfg  = (addr == ADDR_W'(OFS_CFG));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));

  assign wr_ctrl = sel && wr && hit_ctrl;
  assign wr_cfg  = sel && wr && hit_cfg;
  assign wr_stat = sel && wr && hit_stat;

  assign wd_cnt  = wdata[CNT_W-1:0];
  assign wd_act  = wdata[CNT_W];
  assign wd_cfg  = cfg_t'(wdata[CNT_W+2:0]);
  assign wd_flag = wdata[0];
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W+3];

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata[CNT_W:0]   = {act, cnt};
    else if (hit_cfg)  rdata[CNT_W+2:0] = cfg;
    else if (hit_stat) rdata[0]         = flag;
  end

endmodule

// File: rtl/wwd_cfg.sv
module wwd_cfg
  import wwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cfg,
  input  cfg_t wd_cfg,
  output cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.win    <= CNT_RESET;
      cfg.tb     <= 2'd0;
      cfg.ewi_en <= 1'b0;
    end else if (wr_cfg) begin
      cfg.win    <= wd_cfg.win;
      cfg.tb     <= wd_cfg.tb;
      cfg.ewi_en <= cfg.ewi_en | wd_cfg.ewi_en;
    end
  end

  // R6: the enable cannot be withdrawn by a write
  p_en_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ewi_en |=> cfg.ewi_en);

endmodule

// File: rtl/wwd_prescaler.sv
module wwd_prescaler
  import wwd_pkg::*;
#(
  parameter int PRE_LOG2 = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] tb,
  output logic       tick
);

  localparam int PRE_W = PRE_LOG2 + 3;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] last;
  logic [31:0]      len;

  assign len  = period_len(PRE_LOG2, tb);
  assign last = PRE_W'(len - 32'd1);
  assign tick = (pre >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre <= '0;
    else if (clr)   pre <= '0;
    else if (tick)  pre <= '0;
    else            pre <= pre + 1'b1;
  end

  // R11: a counter write restarts the period
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre == '0));

endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wd_cnt,
  input  logic             wd_act,
  input  logic             wr_stat,
  input  logic             wd_flag,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             act,
  output logic             flag,
  output logic             rst_req
);

  logic fired;
  logic step;
  logic ev_timeout, ev_early, ev_arm, ev_fire, ev_warn;

  assign step       = tick && !wr_ctrl;
  assign ev_timeout = step && act && (cnt == CNT_WARN);
  assign ev_early   = wr_ctrl && act && refresh_early(cnt, win);
  assign ev_arm     = wr_ctrl && wd_act && !wd_cnt[CNT_W-1];
  assign ev_fire    = (ev_timeout || ev_early || ev_arm) && !fired;
  assign ev_warn    = step && (cnt == CNT_WARN + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_RESET;
      act     <= 1'b0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
      fired   <= 1'b0;
    end else begin
      if (wr_ctrl)   cnt <= wd_cnt;
      else if (tick) cnt <= cnt - 1'b1;
      act <= act | (wr_ctrl & wd_act);
      if (ev_warn)                  flag <= 1'b1;
      else if (wr_stat && !wd_flag) flag <= 1'b0;
      rst_req <= ev_fire;
      fired   <= fired | ev_fire;
    end
  end

  // R3: timeout crossing while active requests reset
  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && tick && !wr_ctrl && cnt == CNT_WARN && !fired) |=> rst_req);

  // R4: activation is sticky
  p_act_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> act);

  // R5: reaching the warning value raises the flag
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_ctrl && cnt == 7'h41) |=> flag);

  // R7: single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7: no second pulse after the first
  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !rst_req) |=> !rst_req);

  // R8: early refresh while active requests reset
  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && act && cnt > win && !fired) |=> rst_req);

  // R9: no reset while inactive unless a write arms the block
  p_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !wr_ctrl) |=> !rst_req);

endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int PRE_LOG2 = 12,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic              ewi_irq
);

  logic             wr_ctrl, wr_cfg, wr_stat;
  logic [CNT_W-1:0] wd_cnt, cnt;
  logic             wd_act, wd_flag, act, flag, tick;
  cfg_t             wd_cfg, cfg;

  wwd_bus #(.ADDR_W(ADDR_W)) u_bus (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .act(act), .cfg(cfg), .flag(flag),
    .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg), .wr_stat(wr_stat),
    .wd_cnt(wd_cnt), .wd_act(wd_act), .wd_cfg(wd_cfg), .wd_flag(wd_flag),
    .rdata(bus_rdata)
  );

  wwd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wd_cfg(wd_cfg), .cfg(cfg)
  );

  wwd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctrl), .tb(cfg.tb), .tick(tick)
  );

  wwd_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_ctrl(wr_ctrl), .wd_cnt(wd_cnt), .wd_act(wd_act),
    .wr_stat(wr_stat), .wd_flag(wd_flag), .win(cfg.win),
    .cnt(cnt), .act(act), .flag(flag), .rst_req(rst_req)
  );

  assign ewi_irq = flag & cfg.ewi_en;

endmodule

// File: tb/sim_wwd_top.sv
`timescale 1ns/1ps
module sim_wwd_top;

  localparam int PL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req, ewi_irq;

  int vectors = 0, miscompares = 0, pulses = 0;
  bit done = 0;

  wwd_top #(.PRE_LOG2(PL), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .ewi_irq(ewi_irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(2);
    rst_n = 1;
    pulses = 0;
  endtask

  function automatic int per(input int tb);
    return 1 << (PL + tb);
  endfunction

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl", d, 32'h7F);
    rd(4'h4, d); chk("R1 cfg", d, 32'h7F);
    rd(4'h8, d); chk("R1 stat", d, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    chk("R1 irq", {31'b0, ewi_irq}, 0);

    // R2 period for each time base
    for (int tb = 0; tb < 4; tb++) begin
      do_reset();
      wr(4'h4, (tb << 7) | 32'h7F);
      wr(4'h0, 32'h50);
      cyc(per(tb) - 1); rd(4'h0, d); chk("R2 before step", d, 32'h50);
      cyc(1);           rd(4'h0, d); chk("R2 at step", d, 32'h4F);
      cyc(per(tb) * 3); rd(4'h0, d); chk("R2 three more", d, 32'h4C);
    end

    // R5 R6 early warning
    do_reset();
    wr(4'h0, 32'h41);
    cyc(per(0) - 1); rd(4'h8, d); chk("R5 flag not yet", d, 0);
    cyc(1);          rd(4'h8, d); chk("R5 flag set without enable", d, 1);
    chk("R6 irq masked", {31'b0, ewi_irq}, 0);
    wr(4'h8, 32'h1); rd(4'h8, d); chk("R5 write one keeps flag", d, 1);
    wr(4'h4, 32'h27F); chk("R6 irq enabled", {31'b0, ewi_irq}, 1);
    wr(4'h4, 32'h07F); rd(4'h4, d); chk("R6 enable sticky", d, 32'h27F);
    chk("R6 irq still on", {31'b0, ewi_irq}, 1);
    wr(4'h8, 32'h0); rd(4'h8, d); chk("R5 write zero clears", d, 0);
    chk("R6 irq follows flag", {31'b0, ewi_irq}, 0);
    // R9 inactive crossing
    cyc(per(0) * 6); rd(4'h0, d);
    chk("R9 counter passed 0x3F", {31'b0, d[6:0] < 7'h3F}, 1);
    chk("R9 no reset while inactive", pulses, 0);

    // R3 R4 R7 timeout
    do_reset();
    wr(4'h0, 32'hC1);
    cyc(per(0)); rd(4'h0, d); chk("R3 at 0x40", d, 32'hC0);
    chk("R3 no reset at 0x40", {31'b0, rst_req}, 0);
    cyc(per(0) - 1); chk("R3 not early", {31'b0, rst_req}, 0);
    cyc(1); chk("R3 reset on crossing", {31'b0, rst_req}, 1);
    rd(4'h0, d); chk("R3 counter 0x3F", d, 32'hBF);
    cyc(1); chk("R7 pulse one cycle", {31'b0, rst_req}, 0);
    wr(4'h0, 32'h7F); rd(4'h0, d); chk("R4 active stays set", d, 32'hFF);
    cyc(per(0) * 70); chk("R7 no second pulse", pulses, 1);

    // R8 window sweep, window 0x60
    for (int c = 'h7F; c >= 'h41; c--) begin
      do_reset();
      wr(4'h4, 32'h060);
      wr(4'h0, 32'hFF);
      cyc(('h7F - c) * per(0));
      rd(4'h0, d); chk("R8 counter before refresh", d, 32'h80 | c);
      wr(4'h0, 32'hFF);
      chk("R8 refresh vs window", {31'b0, rst_req}, (c > 'h60) ? 1 : 0);
    end

    // R10 arming with bit 6 clear
    do_reset();
    wr(4'h0, 32'h20); chk("R10 no arm no reset", {31'b0, rst_req}, 0);
    wr(4'h0, 32'hA0); chk("R10 arm with low counter", {31'b0, rst_req}, 1);

    // R11 prescaler restart on write
    do_reset();
    wr(4'h0, 32'h60);
    cyc(2);
    wr(4'h0, 32'h60);
    cyc(per(0) - 1); rd(4'h0, d); chk("R11 full period after refresh", d, 32'h60);
    cyc(1);          rd(4'h0, d); chk("R11 step after full period", d, 32'h5F);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule